// File: doc/BRIEF.md
# Configuration Cycle Address Generator

This block turns a configuration-space request (bus number, device/function number and register offset) into two registered values. The first is the byte offset inside a 16 MB configuration aperture. The second is a 16-bit window map value that a host bridge programs into its outbound translation window. A host uses the pair to reach the configuration registers of any function in the hierarchy.

Requests for bus 0 produce type 0 cycles, which address the directly attached segment. Here the device select is a one-hot bit. For low slot numbers that bit is placed in the address. For higher slot numbers it moves into the upper field of the map value, because the address bits run out. Requests for any other bus produce type 1 cycles, which carry bus, slot and function in the address for bridges further down to decode.

A type 0 slot whose select bit would fall past the top of the map value cannot be encoded. Such a request is reported on an error flag instead of producing a result.

Top module: `cfg_addr_gen`

## Requirements
- R1: After reset, cfgValid and cfgError are 0, cfgAddr is 0 and mapValue is 0.
- R2: Exactly one of cfgValid or cfgError pulses high for one cycle, on the clock edge after the one at which reqStrobe is sampled high. When no request is sampled, cfgAddr and mapValue hold their previous values.
- R3: If busNum is 0, the result is type 0 and mapValue bit 0 is 0. For any other busNum, the result is type 1 and mapValue bit 0 is 1.
- R4: Every accepted result has mapValue bits 3:1 equal to 3'b101, which is the configuration cycle code.
- R5: For type 0 with slot = devFn[7:3] at most 12, cfgAddr carries devFn[2:0] at bits 10:8 and has bit (slot + 11) set. No other bit of cfgAddr bits 23:11 is set, and mapValue bits 15:4 are 0.
- R6: For type 0 with a slot from 13 to 20, mapValue has bit (slot - 5) set and its other bits of 15:4 clear. cfgAddr bits 23:11 are 0, and devFn[2:0] is still at bits 10:8.
- R7: For type 1, cfgAddr bits 23:16 equal busNum and bits 15:8 equal devFn. Every slot from 0 to 31 is accepted, and mapValue equals 16'h000B.
- R8: regOffset is added to the generated address, so it appears in cfgAddr bits 7:0 for every accepted result.
- R9: For type 0 with a slot from 21 to 31, cfgError pulses instead of cfgValid, and cfgAddr and mapValue are both set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqStrobe | input | 1 | Request; the inputs are sampled when it is high |
| busNum | input | 8 | Target bus number |
| devFn | input | 8 | Slot in bits 7:3, function in bits 2:0 |
| regOffset | input | 8 | Register byte offset within the function |
| cfgAddr | output | 24 | Offset inside the configuration aperture |
| mapValue | output | 16 | Window map value: select field, cycle code, low-bits enable |
| cfgValid | output | 1 | One-cycle pulse: the result is valid |
| cfgError | output | 1 | One-cycle pulse: the type 0 slot cannot be encoded |

## Verification
The hardest cases to reach are the seams of the type 0 select split. These sit between slots 12 and 13, where the one-hot bit moves from the address into the map value, and between slots 20 and 21, where encoding is no longer possible. The stimulus reaches them by sweeping all 256 devFn values for bus 0 and for several nonzero buses, each with several register offsets. This covers every slot and function on both sides of each boundary. After every request, the bench spends one idle cycle confirming that the outputs hold and that neither pulse repeats.

// File: rtl/cfg_addr_pkg.sv
package cfg_addr_pkg;
  // strobes handed from control to datapath
  typedef struct packed {
    logic load;       // capture a new result
    logic typeOne;    // bus behind another bridge
    logic directSel;  // select bit lives in the address
    logic badSlot;    // type 0 slot beyond the map field
  } cfgStrobes_t;

  localparam logic [2:0] CYCLE_CODE_CFG = 3'b101;
endpackage

// File: rtl/cfg_addr_ctrl.sv
module cfg_addr_ctrl
  import cfg_addr_pkg::*;
#(
  parameter int BUS_W         = 8,
  parameter int SLOT_W        = 5,
  parameter int MAP_W         = 16,
  parameter int MAP_SEL_SHIFT = 5,
  parameter int DIRECT_MAX    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStrobe,
  input  logic [BUS_W-1:0]  busNum,
  input  logic [SLOT_W-1:0] slot,
  output cfgStrobes_t       strobes,
  output logic              cfgValid,
  output logic              cfgError
);
  // highest type 0 slot whose select bit still fits the map value
  localparam int MAP_SLOT_MAX = MAP_W - 1 + MAP_SEL_SHIFT;

  always_comb begin
    strobes.load      = reqStrobe;
    strobes.typeOne   = (busNum != '0);
    strobes.directSel = (int'(slot) <= DIRECT_MAX);
    strobes.badSlot   = !strobes.typeOne && (int'(slot) > MAP_SLOT_MAX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgValid <= 1'b0;
      cfgError <= 1'b0;
    end else begin
      cfgValid <= reqStrobe && !strobes.badSlot;
      cfgError <= reqStrobe && strobes.badSlot;
    end
  end

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgValid && cfgError));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqStrobe |=> (cfgValid || cfgError));

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqStrobe |=> !(cfgValid || cfgError));
endmodule

// File: rtl/cfg_addr_dp.sv
module cfg_addr_dp
  import cfg_addr_pkg::*;
#(
  parameter int BUS_W         = 8,
  parameter int DEVFN_W       = 8,
  parameter int OFF_W         = 8,
  parameter int ADDR_W        = 24,
  parameter int MAP_W         = 16,
  parameter int ADDR_SEL_BASE = 11,
  parameter int MAP_SEL_SHIFT = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobes_t        strobes,
  input  logic [BUS_W-1:0]   busNum,
  input  logic [DEVFN_W-1:0] devFn,
  input  logic [OFF_W-1:0]   regOffset,
  output logic [ADDR_W-1:0]  cfgAddr,
  output logic [MAP_W-1:0]   mapValue
);
  localparam int FUNC_W   = 3;
  localparam int DEVFN_LSB = 8;
  localparam int BUS_LSB  = DEVFN_LSB + DEVFN_W;

  logic [ADDR_W-1:0] nextAddr;
  logic [MAP_W-1:0]  nextMap;
  logic [DEVFN_W-FUNC_W-1:0] slot;

  assign slot = devFn[DEVFN_W-1:FUNC_W];

  always_comb begin
    nextAddr = '0;
    nextMap  = '0;
    if (!strobes.badSlot) begin
      nextMap[3:1] = CYCLE_CODE_CFG;
      if (strobes.typeOne) begin
        nextMap[0] = 1'b1;
        nextAddr   = (ADDR_W'(busNum) << BUS_LSB) | (ADDR_W'(devFn) << DEVFN_LSB);
      end else begin
        nextAddr = ADDR_W'(devFn[FUNC_W-1:0]) << DEVFN_LSB;
        if (strobes.directSel)
          nextAddr = nextAddr | (ADDR_W'(1) << (int'(slot) + ADDR_SEL_BASE));
        else
          nextMap = nextMap | (MAP_W'(1) << (int'(slot) - MAP_SEL_SHIFT));
      end
      nextAddr = nextAddr + ADDR_W'(regOffset);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgAddr  <= '0;
      mapValue <= '0;
    end else if (strobes.load) begin
      cfgAddr  <= nextAddr;
      mapValue <= nextMap;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(cfgAddr) && $stable(mapValue)));

  assert_type_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.badSlot) |=> (mapValue[0] == (busNum != '0) || $changed(busNum)));
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
  import cfg_addr_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int DEVFN_W    = 8,
  parameter int OFF_W      = 8,
  parameter int ADDR_W     = 24,
  parameter int MAP_W      = 16,
  parameter int DIRECT_MAX = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqStrobe,
  input  logic [BUS_W-1:0]   busNum,
  input  logic [DEVFN_W-1:0] devFn,
  input  logic [OFF_W-1:0]   regOffset,
  output logic [ADDR_W-1:0]  cfgAddr,
  output logic [MAP_W-1:0]   mapValue,
  output logic               cfgValid,
  output logic               cfgError
);
  localparam int SLOT_W        = DEVFN_W - 3;
  localparam int ADDR_SEL_BASE = 11;
  localparam int MAP_SEL_SHIFT = 5;
  localparam int MAP_SEL_LSB   = DIRECT_MAX + 1 - MAP_SEL_SHIFT;

  cfgStrobes_t strobes;

  cfg_addr_ctrl #(
    .BUS_W(BUS_W), .SLOT_W(SLOT_W), .MAP_W(MAP_W),
    .MAP_SEL_SHIFT(MAP_SEL_SHIFT), .DIRECT_MAX(DIRECT_MAX)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqStrobe(reqStrobe), .busNum(busNum),
    .slot(devFn[DEVFN_W-1:3]), .strobes(strobes),
    .cfgValid(cfgValid), .cfgError(cfgError)
  );

  cfg_addr_dp #(
    .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W),
    .MAP_W(MAP_W), .ADDR_SEL_BASE(ADDR_SEL_BASE), .MAP_SEL_SHIFT(MAP_SEL_SHIFT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busNum(busNum),
    .devFn(devFn), .regOffset(regOffset),
    .cfgAddr(cfgAddr), .mapValue(mapValue)
  );

  assert_cycle_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> (mapValue[3:1] == 3'b101));

  // R5 and R6: exactly one device select across the two fields
  assert_single_select_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !mapValue[0]) |->
      ($countones({cfgAddr[ADDR_W-1:ADDR_SEL_BASE], mapValue[MAP_W-1:MAP_SEL_LSB]}) == 1));

  assert_error_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (cfgAddr == '0 && mapValue == '0));
endmodule

// File: tb/test_cfg_addr_gen.sv
module test_cfg_addr_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqStrobe = 1'b0;
  logic [7:0] busNum = '0;
  logic [7:0] devFn = '0;
  logic [7:0] regOffset = '0;
  logic [23:0] cfgAddr;
  logic [15:0] mapValue;
  logic cfgValid, cfgError;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_addr_gen i_cfg_addr_gen (
    .clk(clk), .rstN(rstN), .reqStrobe(reqStrobe), .busNum(busNum),
    .devFn(devFn), .regOffset(regOffset), .cfgAddr(cfgAddr),
    .mapValue(mapValue), .cfgValid(cfgValid), .cfgError(cfgError)
  );

  task automatic check(string req, int ok, longint act, longint exp);
    checks++;
    if (ok == 0) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runReq(int bus, int df, int off);
    int slot, fn, eAddr, eMap, eVld, eErr;
    string tag;
    slot = df / 8;
    fn = df % 8;
    eVld = 1; eErr = 0;
    if (bus != 0) begin
      tag = "R7 R3 R8";
      eAddr = bus * 65536 + df * 256 + off;
      eMap = 11;
    end else if (slot <= 12) begin
      tag = "R5 R3 R4 R8";
      eAddr = fn * 256 + (2 ** (slot + 11)) + off;
      eMap = 10;
    end else if (slot <= 20) begin
      tag = "R6 R3 R4 R8";
      eAddr = fn * 256 + off;
      eMap = 10 + (2 ** (slot - 5));
    end else begin
      tag = "R9";
      eAddr = 0; eMap = 0; eVld = 0; eErr = 1;
    end
    @(negedge clk);
    busNum = 8'(bus); devFn = 8'(df); regOffset = 8'(off); reqStrobe = 1'b1;
    @(negedge clk);
    reqStrobe = 1'b0;
    // disturb inputs while idle; outputs must not follow
    busNum = 8'(bus + 1); devFn = 8'(df + 5);
    check({tag, " result"},
          int'(cfgAddr == 24'(eAddr) && mapValue == 16'(eMap) &&
               cfgValid == eVld[0] && cfgError == eErr[0]),
          {cfgValid, cfgError, 16'(mapValue), 24'(cfgAddr)},
          {eVld[0], eErr[0], 16'(eMap), 24'(eAddr)});
    @(negedge clk);
    check("R2 hold", int'(cfgAddr == 24'(eAddr) && mapValue == 16'(eMap) &&
                          !cfgValid && !cfgError),
          {cfgValid, cfgError, 16'(mapValue), 24'(cfgAddr)},
          {2'b00, 16'(eMap), 24'(eAddr)});
  endtask

  initial begin
    int buses[4] = '{0, 1, 8'h5A, 8'hFF};
    int offs[3] = '{0, 8'h3C, 8'hFF};
    repeat (3) @(negedge clk);
    check("R1 reset", int'(cfgAddr == 0 && mapValue == 0 && !cfgValid && !cfgError),
          {cfgValid, cfgError, 16'(mapValue), 24'(cfgAddr)}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(!cfgValid && !cfgError && cfgAddr == 0),
          {cfgValid, cfgError, 24'(cfgAddr)}, 0);
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 3; o++)
        for (int d = 0; d < 256; d++)
          runReq(buses[b], d, offs[o]);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule